// File: doc/BRIEF.md
# Register-Immediate Integer ALU

A purely combinational arithmetic and logic unit for the execute stage of a 32-bit load/store processor. Each cycle it receives two register operands, a 16-bit immediate, a 5-bit shift-amount field, a 6-bit primary opcode and a 6-bit function code. From these it produces a 32-bit result, a signed-overflow flag and an illegal-operation flag.

Selection uses two levels. A primary opcode of zero means the register form, and the function code then picks the operation. Any other primary opcode picks an immediate form directly. Register forms compute `rs op rt`. Immediate forms compute `rs op ext(imm)`, and the extension of the immediate depends on the operation. Shifts always act on `rt`. The pipeline around the block writes the result back and uses the overflow flag to raise a trap. Register read, memory, branch decision and multiply/divide are handled elsewhere.

Top module: `ri_alu`

## Requirements
- R1: With opcode 0, the function codes 32 (add), 34 (sub, rs minus rt), 36 (and), 37 (or), 38 (xor) and 39 (nor) return the named operation on rs and rt. The function codes 33 and 35 return the same sum and difference as 32 and 34.
- R2: The immediate opcodes 8 (addi) and 9 (addiu) return rs plus the immediate sign-extended from bit 15 to 32 bits.
- R3: The overflow output is 1 exactly when add (fn 32), sub (fn 34) or addi (op 8) has a two's-complement result whose sign does not match the operand signs. For addu (fn 33), subu (fn 35), addiu (op 9) and every other operation it is 0.
- R4: slt (op 0, fn 42) and slti (op 10, with the immediate sign-extended) return 1 when rs is less than the second operand as signed numbers, and 0 otherwise.
- R5: lui (op 15) returns the immediate in bits 31..16 and zero in bits 15..0. rs plays no part in the result.
- R6: The shift function codes 0 (left logical), 2 (right logical) and 3 (right arithmetic) shift rt by the 5-bit shift-amount field. Codes 4, 6 and 7 do the same shifts by the low 5 bits of rs, and the upper bits of rs are ignored.
- R7: Arithmetic right shifts (fn 3 and 7) fill the vacated bits with bit 31 of rt. Logical shifts fill with zero.
- R8: andi (op 12), ori (op 13) and xori (op 14) zero-extend the immediate before the logic operation.
- R9: Any other opcode, or any other function code under opcode 0, gives result 0, illegal 1 and overflow 0. Every defined operation gives illegal 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Primary opcode; 0 selects the register form |
| fn_code | input | 6 | Function code, used only when op_code is 0 |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand and shift source |
| imm_val | input | 16 | Immediate field |
| sh_amt | input | 5 | Shift-amount field for the fixed shifts |
| result | output | 32 | Operation result |
| overflow | output | 1 | Signed overflow of add, sub or addi |
| illegal | output | 1 | Undefined opcode or function combination |

## Verification
Directed vectors place operands on the sign boundaries: the most positive and most negative values, and sums just inside and just outside the range. These vectors separate the trapping add/sub/addi forms from the non-trapping ones, and they show whether slt compares signed or unsigned. An immediate with bit 15 set separates sign extension from zero extension between the arithmetic and logic immediate forms. Shifts by 0 and 31 on a negative rt, with the upper bits of rs set, separate arithmetic fill from logical fill and show that only five bits of rs are used. Constrained random vectors spread over every legal code, plus random codes that are mostly illegal, test the decode of both levels against the bench's own model.

// File: rtl/ri_alu_pkg.sv
// Package ri_alu_pkg
// Holds the encoding constants and the decoded-control types that the
// ALU submodules share. It assumes a 6-bit opcode and a 6-bit function code.
package ri_alu_pkg;

    localparam int CODE_W = 6;

    // primary opcodes
    localparam logic [CODE_W-1:0] OPC_REG   = 6'd0;
    localparam logic [CODE_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [CODE_W-1:0] OPC_ADDIU = 6'd9;
    localparam logic [CODE_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [CODE_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [CODE_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [CODE_W-1:0] OPC_XORI  = 6'd14;
    localparam logic [CODE_W-1:0] OPC_LUI   = 6'd15;

    // function codes under the register form
    localparam logic [CODE_W-1:0] FN_SLL  = 6'd0;
    localparam logic [CODE_W-1:0] FN_SRL  = 6'd2;
    localparam logic [CODE_W-1:0] FN_SRA  = 6'd3;
    localparam logic [CODE_W-1:0] FN_SLLV = 6'd4;
    localparam logic [CODE_W-1:0] FN_SRLV = 6'd6;
    localparam logic [CODE_W-1:0] FN_SRAV = 6'd7;
    localparam logic [CODE_W-1:0] FN_ADD  = 6'd32;
    localparam logic [CODE_W-1:0] FN_ADDU = 6'd33;
    localparam logic [CODE_W-1:0] FN_SUB  = 6'd34;
    localparam logic [CODE_W-1:0] FN_SUBU = 6'd35;
    localparam logic [CODE_W-1:0] FN_AND  = 6'd36;
    localparam logic [CODE_W-1:0] FN_OR   = 6'd37;
    localparam logic [CODE_W-1:0] FN_XOR  = 6'd38;
    localparam logic [CODE_W-1:0] FN_NOR  = 6'd39;
    localparam logic [CODE_W-1:0] FN_SLT  = 6'd42;

    typedef enum logic [3:0] {
        K_NONE,
        K_ADD,
        K_SUB,
        K_SLT,
        K_AND,
        K_OR,
        K_XOR,
        K_NOR,
        K_SHL,
        K_SHRL,
        K_SHRA,
        K_LUI
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_imm;
        logic      imm_zext;
        logic      var_shift;
        logic      ovf_en;
        logic      illegal;
    } alu_ctl_t;

endpackage

// File: rtl/ri_alu_decode.sv
// Module ri_alu_decode
// Turns the two-level opcode/function encoding into one control word.
// Assumes the caller ignores fn_code whenever op_code is not the register form.
module ri_alu_decode
    import ri_alu_pkg::*;
(
    input  logic [CODE_W-1:0] op_code,
    input  logic [CODE_W-1:0] fn_code,
    output alu_ctl_t          ctl
);

    // Purpose: map the opcode and function code to an operation and its operand options.
    always_comb begin
        ctl = '{kind: K_NONE, use_imm: 1'b0, imm_zext: 1'b0,
                var_shift: 1'b0, ovf_en: 1'b0, illegal: 1'b0};
        if (op_code == OPC_REG) begin
            unique case (fn_code)
                FN_SLL:  ctl.kind = K_SHL;
                FN_SRL:  ctl.kind = K_SHRL;
                FN_SRA:  ctl.kind = K_SHRA;
                FN_SLLV: begin ctl.kind = K_SHL;  ctl.var_shift = 1'b1; end
                FN_SRLV: begin ctl.kind = K_SHRL; ctl.var_shift = 1'b1; end
                FN_SRAV: begin ctl.kind = K_SHRA; ctl.var_shift = 1'b1; end
                FN_ADD:  begin ctl.kind = K_ADD;  ctl.ovf_en = 1'b1; end
                FN_ADDU: ctl.kind = K_ADD;
                FN_SUB:  begin ctl.kind = K_SUB;  ctl.ovf_en = 1'b1; end
                FN_SUBU: ctl.kind = K_SUB;
                FN_AND:  ctl.kind = K_AND;
                FN_OR:   ctl.kind = K_OR;
                FN_XOR:  ctl.kind = K_XOR;
                FN_NOR:  ctl.kind = K_NOR;
                FN_SLT:  ctl.kind = K_SLT;
                default: ctl.illegal = 1'b1;
            endcase
        end else begin
            ctl.use_imm = 1'b1;
            unique case (op_code)
                OPC_ADDI:  begin ctl.kind = K_ADD; ctl.ovf_en = 1'b1; end
                OPC_ADDIU: ctl.kind = K_ADD;
                OPC_SLTI:  ctl.kind = K_SLT;
                OPC_ANDI:  begin ctl.kind = K_AND; ctl.imm_zext = 1'b1; end
                OPC_ORI:   begin ctl.kind = K_OR;  ctl.imm_zext = 1'b1; end
                OPC_XORI:  begin ctl.kind = K_XOR; ctl.imm_zext = 1'b1; end
                OPC_LUI:   ctl.kind = K_LUI;
                default: begin
                    ctl.use_imm = 1'b0;
                    ctl.illegal = 1'b1;
                end
            endcase
        end
    end

    // Purpose: an undefined code must never enable the overflow trap (R9, R3).
    always_comb begin
        if (ctl.illegal) begin
            p_illegal_quiet_r9: assert (ctl.kind == K_NONE && !ctl.ovf_en)
                else $error("illegal decode carries an operation");
        end
    end

endmodule

// File: rtl/ri_alu_addsub.sv
// Module ri_alu_addsub
// Two's-complement adder/subtractor. It also gives the signed-overflow
// condition and the signed less-than for the compare forms.
// Assumes the operands are already extended to the full width.
module ri_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt
);

    logic [W-1:0] b_eff;

    // Purpose: invert b for subtraction and form the sum with a carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    end

    // Purpose: signed overflow and signed less-than from the operand and sum signs.
    always_comb begin
        ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        lt  = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
    end

    // Purpose: mixed-sign add and same-sign subtract can never overflow (R3).
    always_comb begin
        if (!sub && (a[W-1] != b[W-1])) begin
            p_no_overflow_r3: assert (!ovf) else $error("mixed-sign add overflowed");
        end
        if (sub && (a[W-1] == b[W-1])) begin
            p_no_sub_overflow_r3: assert (!ovf) else $error("same-sign sub overflowed");
        end
    end

endmodule

// File: rtl/ri_alu_shifter.sv
// Module ri_alu_shifter
// Log-depth barrel shifter. A left shift reverses the data, shifts right and
// reverses back. Assumes W is a power of two and amt has clog2(W) bits.
module ri_alu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          dir_left,
    input  logic          arith,
    output logic [W-1:0]  dout
);

    logic [W-1:0] din_rev;
    logic [W-1:0] stg_out_rev;
    logic [W-1:0] stg [SW+1];
    logic         fill;

    // Purpose: bit-reverse the input and the output for the left-shift path.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din_rev[i]     = din[W-1-i];
        assign stg_out_rev[i] = stg[SW][W-1-i];
    end

    assign fill   = arith & ~dir_left & din[W-1];
    assign stg[0] = dir_left ? din_rev : din;

    // Purpose: each stage shifts right by a power of two when its amount bit is set.
    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
    end

    assign dout = dir_left ? stg_out_rev : stg[SW];

    // Purpose: arithmetic right shift keeps the sign bit (R7); a zero amount leaves data unchanged (R6).
    always_comb begin
        if (arith && !dir_left) begin
            p_sign_kept_r7: assert (dout[W-1] == din[W-1]) else $error("sign lost");
        end
        if (amt == '0) begin
            p_zero_shift_r6: assert (dout == din) else $error("zero shift changed data");
        end
    end

endmodule

// File: rtl/ri_alu.sv
// Module ri_alu
// Combinational register/immediate ALU. It decodes the two-level code, extends
// the immediate, and selects among the adder, the shifter and the logic results.
// Assumes operands are stable for the whole cycle; it holds no state.
module ri_alu
    import ri_alu_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 16,
    parameter int SHW  = $clog2(W)
) (
    input  logic [CODE_W-1:0] op_code,
    input  logic [CODE_W-1:0] fn_code,
    input  logic [W-1:0]      rs_val,
    input  logic [W-1:0]      rt_val,
    input  logic [IMMW-1:0]   imm_val,
    input  logic [SHW-1:0]    sh_amt,
    output logic [W-1:0]      result,
    output logic              overflow,
    output logic              illegal
);

    localparam int EXTW = W - IMMW;

    alu_ctl_t     ctl;
    logic [W-1:0] imm_ext;
    logic [W-1:0] opnd_b;
    logic [W-1:0] sum;
    logic         add_ovf;
    logic         less;
    logic [W-1:0] sh_out;
    logic [SHW-1:0] sh_sel;

    ri_alu_decode u_dec (
        .op_code (op_code),
        .fn_code (fn_code),
        .ctl     (ctl)
    );

    // Purpose: extend the immediate, zero for logic forms and sign for arithmetic forms.
    always_comb begin
        imm_ext = ctl.imm_zext ? {{EXTW{1'b0}}, imm_val}
                               : {{EXTW{imm_val[IMMW-1]}}, imm_val};
        opnd_b  = ctl.use_imm ? imm_ext : rt_val;
    end

    ri_alu_addsub #(.W(W)) u_add (
        .a   (rs_val),
        .b   (opnd_b),
        .sub (ctl.kind == K_SUB || ctl.kind == K_SLT),
        .sum (sum),
        .ovf (add_ovf),
        .lt  (less)
    );

    // Purpose: pick the shift distance from the field or from the low bits of rs.
    always_comb begin
        sh_sel = ctl.var_shift ? rs_val[SHW-1:0] : sh_amt;
    end

    ri_alu_shifter #(.W(W), .SW(SHW)) u_sh (
        .din      (rt_val),
        .amt      (sh_sel),
        .dir_left (ctl.kind == K_SHL),
        .arith    (ctl.kind == K_SHRA),
        .dout     (sh_out)
    );

    // Purpose: final result select and flag qualification.
    always_comb begin
        unique case (ctl.kind)
            K_ADD, K_SUB: result = sum;
            K_SLT:        result = {{(W-1){1'b0}}, less};
            K_AND:        result = rs_val & opnd_b;
            K_OR:         result = rs_val | opnd_b;
            K_XOR:        result = rs_val ^ opnd_b;
            K_NOR:        result = ~(rs_val | opnd_b);
            K_SHL, K_SHRL, K_SHRA: result = sh_out;
            K_LUI:        result = {imm_val, {EXTW{1'b0}}};
            default:      result = '0;
        endcase
        overflow = ctl.ovf_en & add_ovf;
        illegal  = ctl.illegal;
    end

    // Purpose: output-level invariants of the select stage.
    always_comb begin
        if (illegal) begin
            p_illegal_zero_r9: assert (result == '0 && !overflow)
                else $error("illegal op produced data");
        end
        if (ctl.kind == K_SLT) begin
            p_compare_bit_r4: assert (result[W-1:1] == '0) else $error("compare wider than 1 bit");
        end
        if (ctl.kind == K_LUI) begin
            p_upper_only_r5: assert (result[EXTW-1:0] == '0 && result[W-1:EXTW] == imm_val)
                else $error("lui low half not clear");
        end
    end

endmodule

// File: tb/ri_alu_tb_top.sv
// Bench for ri_alu: directed corner vectors, then seeded random vectors,
// each compared against a reference model written from the requirements.
module ri_alu_tb_top;

    logic        clk;
    logic        rst_n;
    logic [5:0]  op_code;
    logic [5:0]  fn_code;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [15:0] imm_val;
    logic [4:0]  sh_amt;
    logic [31:0] result;
    logic        overflow;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    ri_alu dut_i (
        .op_code  (op_code),
        .fn_code  (fn_code),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .imm_val  (imm_val),
        .sh_amt   (sh_amt),
        .result   (result),
        .overflow (overflow),
        .illegal  (illegal)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // reference model, written from the requirement list
    task automatic model(input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh,
                         output logic [31:0] r, output logic v,
                         output logic il, output string tag);
        logic [31:0] sx;
        logic [31:0] zx;
        sx = {{16{im[15]}}, im};
        zx = {16'h0000, im};
        r = 32'h0; v = 1'b0; il = 1'b0; tag = "R9";
        if (op == 6'd0) begin
            case (fn)
                6'd32: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); tag = "R3"; end
                6'd33: begin r = a + b; tag = "R1"; end
                6'd34: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); tag = "R3"; end
                6'd35: begin r = a - b; tag = "R1"; end
                6'd36: begin r = a & b; tag = "R1"; end
                6'd37: begin r = a | b; tag = "R1"; end
                6'd38: begin r = a ^ b; tag = "R1"; end
                6'd39: begin r = ~(a | b); tag = "R1"; end
                6'd42: begin r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
                6'd0:  begin r = b << sh; tag = "R6"; end
                6'd2:  begin r = b >> sh; tag = "R6"; end
                6'd3:  begin r = $unsigned($signed(b) >>> sh); tag = "R7"; end
                6'd4:  begin r = b << a[4:0]; tag = "R6"; end
                6'd6:  begin r = b >> a[4:0]; tag = "R6"; end
                6'd7:  begin r = $unsigned($signed(b) >>> a[4:0]); tag = "R7"; end
                default: il = 1'b1;
            endcase
        end else begin
            case (op)
                6'd8:  begin r = a + sx; v = (a[31] == sx[31]) && (r[31] != a[31]); tag = "R2"; end
                6'd9:  begin r = a + sx; tag = "R2"; end
                6'd10: begin r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; tag = "R4"; end
                6'd12: begin r = a & zx; tag = "R8"; end
                6'd13: begin r = a | zx; tag = "R8"; end
                6'd14: begin r = a ^ zx; tag = "R8"; end
                6'd15: begin r = {im, 16'h0000}; tag = "R5"; end
                default: il = 1'b1;
            endcase
        end
    endtask

    // drive one vector on the falling edge, compare on the next rising edge
    task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        logic [31:0] er;
        logic ev;
        logic ei;
        string tg;
        @(negedge clk);
        op_code = op; fn_code = fn; rs_val = a; rt_val = b; imm_val = im; sh_amt = sh;
        model(op, fn, a, b, im, sh, er, ev, ei, tg);
        @(posedge clk);
        #1;
        checks++;
        if (result !== er || overflow !== ev || illegal !== ei) begin
            errors++;
            $display("FAIL %s op=%0d fn=%0d rs=%h rt=%h imm=%h sh=%0d : got r=%h v=%b il=%b exp r=%h v=%b il=%b",
                     tg, op, fn, a, b, im, sh, result, overflow, illegal, er, ev, ei);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [5:0] legal_fn [15] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7, 6'd32, 6'd33,
                                  6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42};
    logic [5:0] legal_op [7]  = '{6'd8, 6'd9, 6'd10, 6'd12, 6'd13, 6'd14, 6'd15};

    initial begin
        void'($urandom(32'd24681));
        rst_n = 1'b0;
        op_code = 6'd0; fn_code = 6'd32; rs_val = '0; rt_val = '0; imm_val = '0; sh_amt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: the add opcode on zero operands gives zero and no flags
        apply(6'd0, 6'd32, 32'h0, 32'h0, 16'h0, 5'd0);
        // R1 logic forms
        apply(6'd0, 6'd36, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0, 5'd0);
        apply(6'd0, 6'd39, 32'h0000_0000, 32'h0000_0000, 16'h0, 5'd0);
        // R3: signed overflow at both boundaries, and none for unsigned forms
        apply(6'd0, 6'd32, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
        apply(6'd0, 6'd33, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
        apply(6'd0, 6'd34, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0);
        apply(6'd0, 6'd35, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0);
        apply(6'd0, 6'd32, 32'h7FFF_FFFE, 32'h0000_0001, 16'h0, 5'd0);
        apply(6'd8, 6'd0, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        apply(6'd9, 6'd0, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        // R2: sign extension of the arithmetic immediate
        apply(6'd9, 6'd0, 32'h0000_0010, 32'h0, 16'h8000, 5'd0);
        // R4: signed compare, including cases where the unsigned order is the reverse
        apply(6'd0, 6'd42, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
        apply(6'd0, 6'd42, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 5'd0);
        apply(6'd0, 6'd42, 32'h0000_0005, 32'h0000_0005, 16'h0, 5'd0);
        apply(6'd10, 6'd0, 32'h0000_0000, 32'h0, 16'hFFFF, 5'd0);
        // R5: lui ignores rs
        apply(6'd15, 6'd0, 32'hDEAD_BEEF, 32'h0, 16'h2110, 5'd0);
        // R8: zero extension of the logic immediate
        apply(6'd12, 6'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);
        apply(6'd13, 6'd0, 32'h0000_0000, 32'h0, 16'hFFFF, 5'd0);
        apply(6'd14, 6'd0, 32'hFFFF_0000, 32'h0, 16'h00FF, 5'd0);
        // R6 / R7: shifts at 0 and 31, variable forms with upper rs bits set
        apply(6'd0, 6'd0, 32'h0, 32'h8000_0001, 16'h0, 5'd31);
        apply(6'd0, 6'd2, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
        apply(6'd0, 6'd3, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
        apply(6'd0, 6'd3, 32'h0, 32'h8765_4321, 16'h0, 5'd0);
        apply(6'd0, 6'd7, 32'hFFFF_FFE4, 32'hF000_0000, 16'h0, 5'd0);
        apply(6'd0, 6'd6, 32'hFFFF_FFE4, 32'hF000_0000, 16'h0, 5'd0);
        apply(6'd0, 6'd4, 32'h0000_0120, 32'h0000_0001, 16'h0, 5'd7);
        // R9: undefined codes at both levels
        apply(6'd0, 6'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3);
        apply(6'd0, 6'd43, 32'h1, 32'h2, 16'h0, 5'd0);
        apply(6'd11, 6'd32, 32'h7FFF_FFFF, 32'h1, 16'h1, 5'd0);
        apply(6'd63, 6'd0, 32'h1, 32'h2, 16'h3, 5'd1);

        // seeded random: mostly legal codes, some fully random codes
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] op;
            logic [5:0] fn;
            int sel;
            sel = $urandom_range(0, 9);
            fn = 6'($urandom());
            if (sel < 5) begin
                op = 6'd0;
                fn = legal_fn[$urandom_range(0, 14)];
            end else if (sel < 8) begin
                op = legal_op[$urandom_range(0, 6)];
            end else begin
                op = 6'($urandom());
            end
            apply(op, fn, $urandom(), $urandom(), 16'($urandom()), 5'($urandom()));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule